// File: doc/BRIEF.md
# Magnitude Moving Averager

This block turns a stream of wide signed filter results into a slowly varying level figure. Each accepted sample is reduced to its absolute value and then shifted right by twenty bits. The block keeps a running mean of the most recent 1024 such scaled magnitudes. Samples arrive with a one-clock strobe at any rate up to one per clock. The mean comes out with its own one-clock strobe and holds its value between updates.

The mean is not recomputed over the whole window. A running total is adjusted once per sample: the newest scaled magnitude is added, and the value written 1024 samples earlier is subtracted. That older value is read from a 1024-entry ring of past scaled magnitudes at the slot about to be overwritten. Until the ring has been filled once after reset, the block treats every slot as holding zero. The total is 28 bits wide, and the output is that total shifted right by ten bits.

Top module: `mag_window_avg`

## Requirements
- R1: While `rst` is high, on the next clock `out_valid` is 0 and `out_avg` is 0. Reset also empties the window, so history from before the reset never contributes.
- R2: `out_valid` is high for exactly one clock, in the second clock after each clock in which `in_valid` was high. It is never high otherwise.
- R3: On clocks where `in_valid` is low, `in_data` is ignored. `out_avg` keeps its value whenever `out_valid` is low.
- R4: The scaled magnitude of a sample is floor(|in_data| / 2^20), with `in_data` read as two's complement. Positive and negative inputs of equal size give the same value.
- R5: The most negative input, -2^37, gives the scaled magnitude 2^17 = 131072 without wrapping.
- R6: While fewer than 1024 samples have been accepted since reset, `out_avg` equals floor(S / 1024). S is the sum of the scaled magnitudes of all samples accepted since reset.
- R7: Once 1024 or more samples have been accepted, `out_avg` equals floor(S / 1024). S is the sum of the scaled magnitudes of the latest 1024 samples only.
- R8: The 28-bit total never overflows. A full window of largest magnitudes gives `out_avg` = 131072, and `out_avg` never exceeds that value.
- R9: Samples on consecutive clocks are all accepted. Each one produces its own strobed result, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a clock carrying a sample |
| in_data | input | 38 | Signed two's-complement filter result |
| out_valid | output | 1 | One-clock strobe for a new mean |
| out_avg | output | 18 | Mean of the scaled magnitudes over the window |

## Verification
The hardest condition to reach from the ports is the ring wrapping. Here the value subtracted is a real sample from 1024 entries earlier rather than zero. A close second is a reset that arrives after the ring already holds nonzero history. The stimulus fills the ring with one level and then streams a second, different level past the wrap point, so every result after the wrap shows the removal of a specific older sample. It then resets with stale data still in the ring and checks that the first few means contain only the new samples. A final back-to-back run of the most negative input fills the whole window, which drives the total to its ceiling.

// File: rtl/mag_window_avg.sv
`timescale 1ns/1ps
module mag_window_avg #(
  parameter int IN_W      = 38,
  parameter int SHIFT     = 20,
  parameter int LOG_DEPTH = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic signed [IN_W-1:0]      in_data,
  output logic                        out_valid,
  output logic [IN_W-SHIFT-1:0]       out_avg
);
  localparam int SCALE_W = IN_W - SHIFT;
  localparam int DEPTH   = 1 << LOG_DEPTH;
  localparam int SUM_W   = SCALE_W + LOG_DEPTH;

  logic [IN_W-1:0]      mag;
  logic [SCALE_W-1:0]   scale;
  logic [SCALE_W-1:0]   ring [DEPTH];
  logic [LOG_DEPTH-1:0] wptr;
  logic                 wrapped;
  logic [SCALE_W-1:0]   new_q, old_q;
  logic                 v1, v2;
  logic [SUM_W-1:0]     sum;

  assign mag   = in_data[IN_W-1] ? (~in_data + 1'b1) : in_data;
  assign scale = mag[IN_W-1:SHIFT];

  always_ff @(posedge clk)
    if (in_valid) ring[wptr] <= scale;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      wrapped <= 1'b0;
      new_q   <= '0;
      old_q   <= '0;
      v1      <= 1'b0;
      v2      <= 1'b0;
      sum     <= '0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      if (in_valid) begin
        new_q <= scale;
        old_q <= wrapped ? ring[wptr] : '0;
        wptr  <= wptr + 1'b1;
        if (&wptr) wrapped <= 1'b1;
      end
      if (v1) sum <= sum + SUM_W'(new_q) - SUM_W'(old_q);
    end
  end

  assign out_valid = v2;
  assign out_avg   = sum[SUM_W-1:LOG_DEPTH];
endmodule

// File: rtl/mag_window_avg_chk.sv
`timescale 1ns/1ps
module mag_window_avg_chk #(
  parameter int AVG_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [AVG_W-1:0] out_avg
);
  logic p1, p2;
  always_ff @(posedge clk) begin
    if (rst) begin
      p1 <= 1'b0;
      p2 <= 1'b0;
    end else begin
      p1 <= in_valid;
      p2 <= p1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_avg == '0));

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  assert_no_spurious_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> p2);

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_avg));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    out_avg <= AVG_W'(1 << (AVG_W - 1)));
endmodule

bind mag_window_avg mag_window_avg_chk #(.AVG_W(IN_W - SHIFT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_avg(out_avg)
);

// File: tb/test_mag_window_avg.sv
`timescale 1ns/1ps
module test_mag_window_avg;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [37:0] in_data = '0;
  logic              out_valid;
  logic [17:0]       out_avg;

  int checks = 0;
  int fails  = 0;

  longint hist [1024];
  int     cnt  = 0;
  longint msum = 0;

  localparam int NV = 10;
  localparam longint VEC_IN [NV] = '{
    64'sd5242880, -64'sd5242880, 64'sd4194303, -64'sd4194303, 64'sd1048575,
    -64'sd1, 64'sd104857600000, -64'sd137437904896, -64'sd137438953472, 64'sd137438953471 };
  localparam longint VEC_SC [NV] = '{
    5, 5, 3, 3, 0, 0, 100000, 131071, 131072, 131071 };

  mag_window_avg i_mag_window_avg (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_avg(out_avg));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint scale_of(input longint x);
    longint a = (x < 0) ? -x : x;
    return a >> 20;
  endfunction

  function automatic longint push(input longint s);
    longint old = (cnt >= 1024) ? hist[cnt % 1024] : 0;
    hist[cnt % 1024] = s;
    cnt++;
    msum = msum + s - old;
    return msum >> 10;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cnt = 0; msum = 0;
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(out_avg == 0, "R1 avg", out_avg, 0);
  endtask

  task automatic apply(input longint x, input longint e, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = x[37:0];
    @(negedge clk);
    in_valid = 1'b0; in_data = ~in_data;
    chk(out_valid == 1'b0, "R2 early", out_valid, 0);
    @(negedge clk);
    in_data = 38'h15_5555_5555;
    chk(out_valid == 1'b1, "R2 strobe", out_valid, 1);
    chk(longint'(out_avg) == e, req, out_avg, e);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 single", out_valid, 0);
    chk(longint'(out_avg) == e, "R3 hold", out_avg, e);
    @(negedge clk);
    chk(longint'(out_avg) == e, "R3 ignored", out_avg, e);
  endtask

  task automatic stream(input longint x, input int n, input string req);
    bit     d1v = 0, d2v = 0;
    longint d1e = 0, d2e = 0;
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      chk(out_valid == d2v, "R9 strobe", out_valid, d2v);
      if (d2v) chk(longint'(out_avg) == d2e, req, out_avg, d2e);
      d2v = d1v; d2e = d1e;
      if (i < n) begin
        in_valid = 1'b1; in_data = x[37:0];
        d1v = 1'b1; d1e = push(scale_of(x));
      end else begin
        in_valid = 1'b0; in_data = '0;
        d1v = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++)
      apply(VEC_IN[i], push(VEC_SC[i]), (i >= 8) ? "R5 extreme" : "R4 R6 scale");
    stream(64'sd2097152000, 1014, "R6 fill");
    stream(-64'sd7340032005, 600, "R7 slide");
    do_reset();
    stream(64'sd31457280000, 5, "R1 R6 stale history");
    apply(-64'sd31457280000, push(30000), "R6 after reset");
    do_reset();
    stream(-64'sd137438953472, 1100, "R8 full scale");
    chk(out_avg == 18'd131072, "R8 ceiling", out_avg, 131072);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule